// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire serial slave that lets a bus controller read and write a small array of 8-bit configuration registers. The controller addresses the slave, sends a command byte, and then either writes data or issues a repeated start and reads data back. Bit 7 of the command picks the access style: a single register at an indexed offset, or a counted block that always begins at offset zero and walks upward. The register array loads its default contents on reset, so a system that never touches the bus still sees a known configuration.

Both bus lines arrive as open-drain inputs. Each is synchronised and passed through a two-sample agreement filter, and only then is it checked for START, STOP and clock edges. The slave never drives a line high. It only asserts a pull-low enable for SDA. On-chip logic reads any register through a combinational lookup port. Every register update is also announced on a one-cycle write strobe with address and data. That strobe is valid-only: it has no ready and cannot be back-pressured, because the register array inside the block has already accepted the value.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset every register holds its default value: register i holds bits [8i+7:8i] of DEF_VALS.
- R2: The slave acknowledges the address byte D2h (write) and D3h (read), i.e. 7-bit address 69h followed by the direction bit. It leaves SDA released during the acknowledge slot for any other address and ignores the rest of that transfer.
- R3: A command byte with bit 7 = 1 selects byte mode and bits 6:0 give the offset. The next data byte is written to that offset, with exactly one write strobe.
- R4: In byte mode, a repeated start with address D3h returns the register at the commanded offset, most significant bit first.
- R5: A command byte of 00h selects block mode. In a block write the first data byte is a count N, and the next N bytes go to offsets 0, 1, 2 and upward.
- R6: A block write that ends with a STOP after any complete byte keeps the bytes already written. Registers past that point keep their previous values.
- R7: In a block read the slave first returns the register count (NREGS) and then the registers from offset 0 upward. It releases SDA once the controller NACKs.
- R8: A START seen part-way through a byte discards that byte without writing and restarts the address phase.
- R9: The slave acknowledges every byte written to it, including data bytes beyond a block count and bytes aimed at absent offsets. Such bytes cause no write.
- R10: An offset at or above NREGS is never written, and reading it returns 00h.
- R11: The slave changes its pull-low enable only while the filtered SCL is low, and never drives SDA while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset; loads register defaults |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| wr_valid | output | 1 | One-cycle strobe for each register update (no back-pressure) |
| wr_addr | output | 7 | Offset written while wr_valid is high |
| wr_data | output | 8 | Value written while wr_valid is high |
| loc_addr | input | 7 | Offset for the local combinational read port |
| loc_data | output | 8 | Register at loc_addr, or 00h when out of range |

## Verification
The bound checker watches on every cycle that the pull-low enable moves only while SCL is low and stays off in idle, that no write strobe ever names an absent offset, and that strobes are single cycles raised during the low half of SCL. Whether the right bytes land in the right registers cannot be seen one cycle at a time. The block ordering and count, early termination, mid-byte aborts and read-back values are shown only by the bench's bus transactions, which compare the results against a register model.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WR,
    ST_TX,
    ST_WAIT
  } smb_state_t;

  localparam int unsigned OFS_W  = 7;
  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/smb_pin_cond.sv
module smb_pin_cond #(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_i,
  output logic [LINES-1:0] pin_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic s_meta, s_sync, s_prev, s_out;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_meta <= 1'b1;
        s_sync <= 1'b1;
        s_prev <= 1'b1;
        s_out  <= 1'b1;
      end else begin
        s_meta <= pin_i[g];
        s_sync <= s_meta;
        s_prev <= s_sync;
        if (s_sync == s_prev) s_out <= s_sync;
      end
    end
    assign pin_o[g] = s_out;
  end

endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign ev_start = scl_p & scl_f & sda_p & ~sda_f;
  assign ev_stop  = scl_p & scl_f & ~sda_p & sda_f;
  assign ev_rise  = ~scl_p & scl_f;
  assign ev_fall  = scl_p & ~scl_f;

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs #(
  parameter int                   NREGS    = 8,
  parameter logic [NREGS*8-1:0]   DEF_VALS = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [6:0] waddr,
  input  logic [7:0] wdata,
  input  logic [6:0] ra_a,
  output logic [7:0] rd_a,
  input  logic [6:0] ra_b,
  output logic [7:0] rd_b
);

  localparam int         AW      = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [6:0] LIMIT   = 7'(NREGS);

  logic [7:0] mem [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= DEF_VALS[i*8 +: 8];
    end else if (we && (waddr < LIMIT)) begin
      mem[waddr[AW-1:0]] <= wdata;
    end
  end

  assign rd_a = (ra_a < LIMIT) ? mem[ra_a[AW-1:0]] : 8'h00;
  assign rd_b = (ra_b < LIMIT) ? mem[ra_b[AW-1:0]] : 8'h00;

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smbcfg_pkg::*;
#(
  parameter int                 NREGS    = 8,
  parameter logic [NREGS*8-1:0] DEF_VALS = 64'h9C0FE1407B26D833,
  parameter logic [6:0]         DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       wr_valid,
  output logic [6:0] wr_addr,
  output logic [7:0] wr_data,
  input  logic [6:0] loc_addr,
  output logic [7:0] loc_data
);

  localparam logic [6:0] LIMIT   = 7'(NREGS);
  localparam logic [7:0] COUNT_B = 8'(NREGS);
  localparam logic [6:0] PTR_MAX = 7'h7F;

  logic [1:0] filt;
  logic       scl_f, sda_f;
  logic       ev_start, ev_stop, ev_rise, ev_fall;

  smb_pin_cond #(.LINES(2)) u_cond (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({scl_i, sda_i}),
    .pin_o (filt)
  );
  assign scl_f = filt[1];
  assign sda_f = filt[0];

  smb_bus_events u_ev (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall)
  );

  smb_state_t st, nxt;
  logic [3:0] bit_cnt;
  logic [7:0] sh, tx_sh, left;
  logic [6:0] ptr;
  logic       blk, need_cnt, byte_done, tx_first, oe;
  logic       wv;
  logic [6:0] wa;
  logic [7:0] wd;
  logic [7:0] rd_ptr, tx_byte;
  logic       rx_state, load_tx, in_idle;

  smb_cfg_regs #(.NREGS(NREGS), .DEF_VALS(DEF_VALS)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wv),
    .waddr (wa),
    .wdata (wd),
    .ra_a  (ptr),
    .rd_a  (rd_ptr),
    .ra_b  (loc_addr),
    .rd_b  (loc_data)
  );

  assign rx_state = (st == ST_ADDR) || (st == ST_CMD) || (st == ST_WR);
  assign tx_byte  = tx_first ? COUNT_B : rd_ptr;
  assign load_tx  = ev_fall && (bit_cnt == 4'd9) &&
                    ((st == ST_TX) || ((st == ST_ADDR) && (nxt == ST_TX)));
  assign in_idle  = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      nxt       <= ST_IDLE;
      bit_cnt   <= '0;
      sh        <= '0;
      tx_sh     <= '0;
      left      <= '0;
      ptr       <= '0;
      blk       <= 1'b0;
      need_cnt  <= 1'b0;
      byte_done <= 1'b0;
      tx_first  <= 1'b0;
      oe        <= 1'b0;
      wv        <= 1'b0;
      wa        <= '0;
      wd        <= '0;
    end else begin
      wv <= 1'b0;
      if (ev_start) begin
        st      <= ST_ADDR;
        bit_cnt <= '0;
        oe      <= 1'b0;
      end else if (ev_stop) begin
        st      <= ST_IDLE;
        bit_cnt <= '0;
        oe      <= 1'b0;
      end else if (ev_rise) begin
        if (rx_state) begin
          if (bit_cnt < 4'd8) begin
            sh      <= {sh[6:0], sda_f};
            bit_cnt <= bit_cnt + 4'd1;
          end
        end else if (st == ST_TX) begin
          if (bit_cnt < 4'd8) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (bit_cnt == 4'd8) begin
            if (sda_f) st <= ST_WAIT;
            else       bit_cnt <= 4'd9;
          end
        end
      end else if (ev_fall) begin
        if (rx_state) begin
          if (bit_cnt == 4'd8) begin
            bit_cnt <= 4'd9;
            oe      <= 1'b1;
            nxt     <= ST_WR;
            if (st == ST_ADDR) begin
              if (sh[7:1] != DEV_ADDR) begin
                st      <= ST_WAIT;
                oe      <= 1'b0;
                bit_cnt <= '0;
              end else begin
                nxt      <= sh[0] ? ST_TX : ST_CMD;
                tx_first <= blk;
              end
            end else if (st == ST_CMD) begin
              blk       <= ~sh[7];
              ptr       <= sh[7] ? sh[6:0] : 7'd0;
              need_cnt  <= ~sh[7];
              byte_done <= 1'b0;
            end else begin
              if (blk) begin
                if (need_cnt) begin
                  left     <= sh;
                  need_cnt <= 1'b0;
                end else if (left != 8'd0) begin
                  left <= left - 8'd1;
                  if (ptr < LIMIT) begin
                    wv <= 1'b1;
                    wa <= ptr;
                    wd <= sh;
                  end
                  if (ptr != PTR_MAX) ptr <= ptr + 7'd1;
                end
              end else if (!byte_done) begin
                byte_done <= 1'b1;
                if (ptr < LIMIT) begin
                  wv <= 1'b1;
                  wa <= ptr;
                  wd <= sh;
                end
              end
            end
          end else if (bit_cnt == 4'd9) begin
            bit_cnt <= '0;
            st      <= nxt;
            oe      <= 1'b0;
          end
        end else if (st == ST_TX) begin
          if ((bit_cnt >= 4'd1) && (bit_cnt <= 4'd7)) begin
            tx_sh <= {tx_sh[6:0], 1'b0};
            oe    <= ~tx_sh[6];
          end else if (bit_cnt == 4'd8) begin
            oe <= 1'b0;
          end else if (bit_cnt == 4'd9) begin
            bit_cnt <= '0;
          end
        end
        if (load_tx) begin
          tx_sh <= tx_byte;
          oe    <= ~tx_byte[7];
          if (tx_first)                      tx_first <= 1'b0;
          else if (blk && (ptr != PTR_MAX))  ptr      <= ptr + 7'd1;
        end
      end
    end
  end

  assign sda_oe   = oe;
  assign wr_valid = wv;
  assign wr_addr  = wa;
  assign wr_data  = wd;

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
  parameter int NREGS = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_f,
  input logic       in_idle,
  input logic       wr_valid,
  input logic [6:0] wr_addr
);

  // R11: no pull-low while the slave is idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  // R11: the pull-low enable moves only during the low half of SCL
  a_r11_oe_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f);

  // R10: absent offsets never appear on the write strobe
  a_r10_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr < 7'(NREGS)));

  // R3: each accepted byte gives a single-cycle strobe
  a_r3_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R5: writes are committed while SCL is low, after the byte is complete
  a_r5_wr_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !scl_f);

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREGS(NREGS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .scl_f    (scl_f),
  .in_idle  (in_idle),
  .wr_valid (wr_valid),
  .wr_addr  (wr_addr)
);

// File: tb/sim_smb_cfg_slave.sv
`timescale 1ns/1ps
module sim_smb_cfg_slave;

  localparam int          Q   = 10;
  localparam logic [63:0] DEF = 64'h9C0FE1407B26D833;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe;
  logic       wr_valid;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic [6:0] loc_addr = '0;
  logic [7:0] loc_data;

  int n_tests = 0;
  int n_fail  = 0;
  int wr_seen = 0;
  logic [6:0] last_wa = '0;
  logic [7:0] last_wd = '0;
  logic       done = 1'b0;
  logic [7:0] model [8];

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  smb_cfg_slave u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .loc_addr (loc_addr),
    .loc_data (loc_data)
  );

  always @(posedge clk) if (wr_valid) begin
    wr_seen <= wr_seen + 1;
    last_wa <= wr_addr;
    last_wd <= wr_data;
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bits(logic [7:0] b, int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(logic m_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q);
      scl_m = 1'b0;
    end
    tick(Q);
    sda_m = ~m_ack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(2);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic loc_check(string req, int idx);
    loc_addr = 7'(idx); #1;
    chk(req, loc_data, model[idx]);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) begin
      model[i] = DEF[i*8 +: 8];
      loc_check("R1 default", i);
    end
    chk("R11 idle release", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic t_bad_addr;
    logic a;
    int w0;
    w0 = wr_seen;
    bus_start;
    send_byte(8'hA4, a);
    chk("R2 foreign address nack", {7'd0, a}, 8'h00);
    send_byte(8'h80, a);
    send_byte(8'h55, a);
    bus_stop;
    chk("R2 foreign no write", 8'(wr_seen - w0), 8'h00);
    loc_check("R2 reg0 untouched", 0);
  endtask

  task automatic t_byte_write;
    logic a;
    int w0;
    w0 = wr_seen;
    bus_start;
    send_byte(8'hD2, a); chk("R2 write address ack", {7'd0, a}, 8'h01);
    send_byte(8'h83, a); chk("R9 command ack", {7'd0, a}, 8'h01);
    send_byte(8'h5E, a); chk("R9 data ack", {7'd0, a}, 8'h01);
    bus_stop;
    model[3] = 8'h5E;
    loc_check("R3 byte write value", 3);
    chk("R3 one strobe", 8'(wr_seen - w0), 8'h01);
    chk("R3 strobe addr", {1'b0, last_wa}, 8'h03);
    chk("R3 strobe data", last_wd, 8'h5E);
    loc_check("R3 neighbour kept", 2);
  endtask

  task automatic byte_read(logic [6:0] ofs, output logic [7:0] v);
    logic a;
    bus_start;
    send_byte(8'hD2, a);
    send_byte({1'b1, ofs}, a);
    bus_start;
    send_byte(8'hD3, a); chk("R2 read address ack", {7'd0, a}, 8'h01);
    recv_byte(1'b0, v);
    bus_stop;
  endtask

  task automatic t_byte_read;
    logic [7:0] v;
    byte_read(7'd3, v); chk("R4 read written reg", v, model[3]);
    byte_read(7'd6, v); chk("R4 read default reg", v, model[6]);
    chk("R7 released after nack", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic t_block_write;
    logic a;
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h03, a); chk("R9 count ack", {7'd0, a}, 8'h01);
    send_byte(8'hA1, a);
    send_byte(8'hB2, a);
    send_byte(8'hC3, a);
    bus_stop;
    model[0] = 8'hA1; model[1] = 8'hB2; model[2] = 8'hC3;
    for (int i = 0; i < 4; i++) loc_check("R5 block write", i);
  endtask

  task automatic t_block_early;
    logic a;
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h05, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    bus_stop;
    model[0] = 8'h11; model[1] = 8'h22;
    for (int i = 0; i < 5; i++) loc_check("R6 early stop", i);
  endtask

  task automatic t_block_read;
    logic a;
    logic [7:0] v;
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    bus_start;
    send_byte(8'hD3, a);
    recv_byte(1'b1, v); chk("R7 count byte", v, 8'h08);
    for (int i = 0; i < 8; i++) begin
      recv_byte(i != 7, v);
      chk("R7 block data", v, model[i]);
    end
    chk("R7 release after nack", {7'd0, sda_oe}, 8'h00);
    bus_stop;
  endtask

  task automatic t_range;
    logic a;
    logic [7:0] v;
    int w0;
    w0 = wr_seen;
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h8A, a);
    send_byte(8'h77, a); chk("R9 ack absent offset", {7'd0, a}, 8'h01);
    bus_stop;
    chk("R10 no strobe", 8'(wr_seen - w0), 8'h00);
    byte_read(7'd10, v); chk("R10 read absent", v, 8'h00);
  endtask

  task automatic t_abort;
    logic a;
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h84, a);
    send_bits(8'hF0, 4);
    bus_start;
    send_byte(8'hD2, a); chk("R8 address after abort", {7'd0, a}, 8'h01);
    send_byte(8'h85, a);
    send_byte(8'h99, a);
    bus_stop;
    model[5] = 8'h99;
    loc_check("R8 partial byte dropped", 4);
    loc_check("R8 new transfer written", 5);
  endtask

  task automatic t_extra;
    logic a;
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h01, a);
    send_byte(8'h44, a);
    send_byte(8'h55, a); chk("R9 ack past count", {7'd0, a}, 8'h01);
    bus_stop;
    model[0] = 8'h44;
    loc_check("R9 counted byte", 0);
    loc_check("R9 extra byte ignored", 1);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset;
    t_bad_addr;
    t_byte_write;
    t_byte_read;
    t_block_write;
    t_block_early;
    t_block_read;
    t_range;
    t_abort;
    t_extra;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule